// File: doc/BRIEF.md
# Circular DMA Transfer Channel

A single DMA channel that copies one data item per peripheral request between a fixed or stepping peripheral address and a memory buffer. Software programs a peripheral base address, a memory base address, a transfer total and a control word, then sets the enable bit. From then on every request from the peripheral is served at once. Each service is a read on a single-beat bus master port followed by a write. After the write is accepted the channel returns a one-cycle acknowledge to the peripheral.

A remaining-count register drops by one per served request. Two sticky flags mark the half-buffer and full-buffer points, and each flag can raise the interrupt output through its own enable bit. In circular mode the count and both current addresses return to their programmed values when the count reaches zero, and the channel stays enabled. Software can therefore drain one half of a sample buffer while the channel fills the other half. In one-shot mode the channel turns itself off at zero. A two-bit priority level is held and presented for an arbiter outside the block.

Top module: `cdma_channel`

## Requirements
- R1: After a synchronous reset the channel is disabled. The count, the flags, the priority, the interrupt, the acknowledge and bus_valid are all zero.
- R2: cfg_sel selects the register a write goes to: 0 control, 1 peripheral address, 2 memory address, 3 transfer total. Writes to selections 1 to 3 are ignored while control bit 0 (enable) is set. A write to selection 1 to 3 loads both the programmed value and the current address or count.
- R3: While enabled with a nonzero count, a high req starts a transfer: first a read (bus_write=0) from the source, then a write (bus_write=1) of the unchanged read data to the destination. Control bit 3 selects the direction: 0 is peripheral to memory, 1 is memory to peripheral. No transfer starts while disabled or at count zero.
- R4: While bus_valid is high and bus_ready is low, bus_valid, bus_write and bus_addr hold their values.
- R5: The count drops by exactly one per transfer. ack is high for one cycle, in the cycle after the write is accepted, and the count has already changed in that cycle.
- R6: Control bits 5 and 6 enable stepping of the peripheral and memory address. Bits [8:7] and [10:9] hold the peripheral and memory item size: 0 byte, 1 halfword, 2 word. The step is 1 shifted left by the size. bus_size shows the size of the side currently being accessed.
- R7: half_flag is set when a transfer leaves the count equal to the total shifted right by one. For a total of 1 this happens together with full_flag.
- R8: full_flag is set when a transfer leaves the count at zero. irq = (half_flag and control bit 1) or (full_flag and control bit 2). flag_clr bit 0 clears half_flag and bit 1 clears full_flag. A flag being set in the same cycle takes priority over its clear.
- R9: With control bit 4 (circular) set, reaching zero reloads the count to the total and both current addresses to their bases, and the channel stays enabled.
- R10: With circular mode off, reaching zero clears the enable bit (chan_on goes low), and later requests are not served.
- R11: prio presents control bits [12:11].
- R12: While enabled, a control write changes only bits 0, 1 and 2. Direction, mode, steps, sizes and priority keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| flag_clr | input | 2 | Flag clear strobes (bit 0 half, bit 1 full) |
| req | input | 1 | Peripheral request level |
| ack | output | 1 | One-cycle service acknowledge |
| bus_valid | output | 1 | Bus access request |
| bus_write | output | 1 | 1 write, 0 read |
| bus_addr | output | AW | Bus address |
| bus_size | output | 2 | Item size of the current access |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data |
| bus_ready | input | 1 | Access accepted this cycle |
| chan_on | output | 1 | Enable bit as currently held |
| prio | output | 2 | Stored priority level |
| cnt_left | output | CW | Remaining transfer count |
| half_flag | output | 1 | Half-buffer flag |
| full_flag | output | 1 | Full-buffer flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the channel with AW=16, DW=32 and CW=6. With buffers this short, the half and full points and the circular reload are all reached within a handful of requests. The odd total of 3 and the total of 1 exercise the rounded-down half point and the case where both flags are set together. The 16-bit address space keeps the stepping arithmetic easy to follow. A pseudo-random bus_ready stalls both the read and the write phases, so the hold behaviour and the acknowledge timing are checked against many wait-state patterns.

// File: rtl/cdma_pkg.sv
package cdma_pkg;

    localparam int CFG_W = 32;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_PADDR = 2'd1,
        SEL_MADDR = 2'd2,
        SEL_COUNT = 2'd3
    } cfg_sel_e;

    // Packed control word; the first field is the most significant.
    typedef struct packed {
        logic [1:0] prio;     // [12:11]
        logic [1:0] msize;    // [10:9]
        logic [1:0] psize;    // [8:7]
        logic       minc;     // [6]
        logic       pinc;     // [5]
        logic       circ;     // [4]
        logic       mem2per;  // [3]
        logic       full_ie;  // [2]
        logic       half_ie;  // [1]
        logic       en;       // [0]
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_DONE
    } seq_state_e;

    function automatic logic [3:0] size_step(input logic [1:0] sz);
        return 4'd1 << sz;
    endfunction

    // While the channel runs, only enable and the two interrupt enables move.
    function automatic ctrl_t ctrl_merge(input ctrl_t cur, input ctrl_t wr);
        ctrl_t res;
        if (cur.en) begin
            res         = cur;
            res.en      = wr.en;
            res.half_ie = wr.half_ie;
            res.full_ie = wr.full_ie;
        end else begin
            res = wr;
        end
        return res;
    endfunction

endpackage

// File: rtl/cdma_regs.sv
module cdma_regs
    import cdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             hw_stop,
    output ctrl_t            ctrl,
    output logic [AW-1:0]    pbase,
    output logic [AW-1:0]    mbase,
    output logic [CW-1:0]    total
);

    cfg_sel_e sel;
    assign sel = cfg_sel_e'(cfg_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= '0;
            pbase <= '0;
            mbase <= '0;
            total <= '0;
        end else begin
            if (cfg_we && sel == SEL_CTRL)
                ctrl <= ctrl_merge(ctrl, ctrl_t'(cfg_wdata[CTRL_W-1:0]));
            if (hw_stop)
                ctrl.en <= 1'b0;
            if (cfg_we && !ctrl.en) begin
                case (sel)
                    SEL_PADDR: pbase <= cfg_wdata[AW-1:0];
                    SEL_MADDR: mbase <= cfg_wdata[AW-1:0];
                    SEL_COUNT: total <= cfg_wdata[CW-1:0];
                    default:   ;
                endcase
            end
        end
    end

    // R2
    base_locked_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl.en |=> $stable(pbase) && $stable(mbase) && $stable(total));

    // R12
    ctrl_locked_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl.en |=> $stable(ctrl.prio) && $stable(ctrl.msize) && $stable(ctrl.psize)
                    && $stable(ctrl.minc) && $stable(ctrl.pinc)
                    && $stable(ctrl.circ) && $stable(ctrl.mem2per));

endmodule

// File: rtl/cdma_track.sv
module cdma_track
    import cdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  ctrl_t            ctrl,
    input  logic [AW-1:0]    pbase,
    input  logic [AW-1:0]    mbase,
    input  logic [CW-1:0]    total,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             xfer_done,
    input  logic [1:0]       flag_clr,
    output logic [AW-1:0]    cur_pa,
    output logic [AW-1:0]    cur_ma,
    output logic [CW-1:0]    cnt,
    output logic             half_flag,
    output logic             full_flag,
    output logic             hw_stop
);

    logic [CW-1:0] cnt_nx;
    logic          reach_zero;
    logic          reach_half;
    logic [AW-1:0] pstep;
    logic [AW-1:0] mstep;
    cfg_sel_e      sel;

    assign sel        = cfg_sel_e'(cfg_sel);
    assign cnt_nx     = cnt - 1'b1;
    assign reach_zero = (cnt_nx == '0);
    assign reach_half = (cnt_nx == (total >> 1));
    assign pstep      = AW'(size_step(ctrl.psize));
    assign mstep      = AW'(size_step(ctrl.msize));
    assign hw_stop    = xfer_done && reach_zero && !ctrl.circ;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_pa    <= '0;
            cur_ma    <= '0;
            cnt       <= '0;
            half_flag <= 1'b0;
            full_flag <= 1'b0;
        end else begin
            half_flag <= (half_flag && !flag_clr[0]) || (xfer_done && reach_half);
            full_flag <= (full_flag && !flag_clr[1]) || (xfer_done && reach_zero);
            if (xfer_done) begin
                if (reach_zero && ctrl.circ) begin
                    cnt    <= total;
                    cur_pa <= pbase;
                    cur_ma <= mbase;
                end else begin
                    cnt <= cnt_nx;
                    if (ctrl.pinc) cur_pa <= cur_pa + pstep;
                    if (ctrl.minc) cur_ma <= cur_ma + mstep;
                end
            end else if (cfg_we && !ctrl.en) begin
                case (sel)
                    SEL_PADDR: cur_pa <= cfg_wdata[AW-1:0];
                    SEL_MADDR: cur_ma <= cfg_wdata[AW-1:0];
                    SEL_COUNT: cnt    <= cfg_wdata[CW-1:0];
                    default:   ;
                endcase
            end
        end
    end

    // R5
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= total);

    // R5
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_done && cnt > 1) |=> (cnt == $past(cnt) - 1'b1));

    // R9
    circ_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_done && cnt == 1 && ctrl.circ) |=> (cnt == total && cur_ma == mbase && cur_pa == pbase));

    // R8
    full_set_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_done && cnt == 1) |=> full_flag);

endmodule

// File: rtl/cdma_seq.sv
module cdma_seq
    import cdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go_ok,
    input  logic          req,
    input  logic [AW-1:0] src_addr,
    input  logic [AW-1:0] dst_addr,
    input  logic [1:0]    src_size,
    input  logic [1:0]    dst_size,
    input  logic          bus_ready,
    input  logic [DW-1:0] bus_rdata,
    output logic          bus_valid,
    output logic          bus_write,
    output logic [AW-1:0] bus_addr,
    output logic [1:0]    bus_size,
    output logic [DW-1:0] bus_wdata,
    output logic          xfer_done,
    output logic          ack
);

    seq_state_e    state;
    logic [DW-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            hold_q <= '0;
        end else begin
            case (state)
                ST_IDLE:  if (go_ok && req) state <= ST_READ;
                ST_READ:  if (bus_ready) begin
                              hold_q <= bus_rdata;
                              state  <= ST_WRITE;
                          end
                ST_WRITE: if (bus_ready) state <= ST_DONE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    assign bus_valid = (state == ST_READ) || (state == ST_WRITE);
    assign bus_write = (state == ST_WRITE);
    assign bus_addr  = bus_write ? dst_addr : src_addr;
    assign bus_size  = bus_write ? dst_size : src_size;
    assign bus_wdata = hold_q;
    assign xfer_done = (state == ST_WRITE) && bus_ready;
    assign ack       = (state == ST_DONE);

    // R4
    bus_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_write) && $stable(bus_addr)));

    // R5
    ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    // R3
    read_first_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_valid) |-> !bus_write);

endmodule

// File: rtl/cdma_channel.sv
module cdma_channel
    import cdma_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic [1:0]       flag_clr,
    input  logic             req,
    output logic             ack,
    output logic             bus_valid,
    output logic             bus_write,
    output logic [AW-1:0]    bus_addr,
    output logic [1:0]       bus_size,
    output logic [DW-1:0]    bus_wdata,
    input  logic [DW-1:0]    bus_rdata,
    input  logic             bus_ready,
    output logic             chan_on,
    output logic [1:0]       prio,
    output logic [CW-1:0]    cnt_left,
    output logic             half_flag,
    output logic             full_flag,
    output logic             irq
);

    ctrl_t         ctrl;
    logic [AW-1:0] pbase, mbase, cur_pa, cur_ma;
    logic [CW-1:0] total, cnt;
    logic          hw_stop, xfer_done;
    logic [AW-1:0] src_addr, dst_addr;
    logic [1:0]    src_size, dst_size;

    cdma_regs #(.AW(AW), .CW(CW)) u_regs (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .hw_stop(hw_stop), .ctrl(ctrl),
        .pbase(pbase), .mbase(mbase), .total(total)
    );

    cdma_track #(.AW(AW), .CW(CW)) u_track (
        .clk(clk), .rst(rst), .ctrl(ctrl), .pbase(pbase), .mbase(mbase),
        .total(total), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .xfer_done(xfer_done), .flag_clr(flag_clr), .cur_pa(cur_pa),
        .cur_ma(cur_ma), .cnt(cnt), .half_flag(half_flag),
        .full_flag(full_flag), .hw_stop(hw_stop)
    );

    assign src_addr = ctrl.mem2per ? cur_ma : cur_pa;
    assign dst_addr = ctrl.mem2per ? cur_pa : cur_ma;
    assign src_size = ctrl.mem2per ? ctrl.msize : ctrl.psize;
    assign dst_size = ctrl.mem2per ? ctrl.psize : ctrl.msize;

    cdma_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk(clk), .rst(rst), .go_ok(ctrl.en && cnt != '0), .req(req),
        .src_addr(src_addr), .dst_addr(dst_addr), .src_size(src_size),
        .dst_size(dst_size), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .xfer_done(xfer_done),
        .ack(ack)
    );

    assign chan_on  = ctrl.en;
    assign prio     = ctrl.prio;
    assign cnt_left = cnt;
    assign irq      = (half_flag && ctrl.half_ie) || (full_flag && ctrl.full_ie);

    // R10
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_done && cnt == 1 && !ctrl.circ) |=> !chan_on);

    // R3
    no_start_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_valid && !ack && (!chan_on || cnt_left == '0)) |=> !bus_valid);

endmodule

// File: tb/sim_cdma_channel.sv
module sim_cdma_channel;
    import cdma_pkg::*;

    localparam int AW = 16;
    localparam int DW = 32;
    localparam int CW = 6;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic             rst;
    logic             cfg_we;
    logic [1:0]       cfg_sel;
    logic [CFG_W-1:0] cfg_wdata;
    logic [1:0]       flag_clr;
    logic             req;
    logic             ack, bus_valid, bus_write, bus_ready;
    logic [AW-1:0]    bus_addr;
    logic [1:0]       bus_size, prio;
    logic [DW-1:0]    bus_wdata, bus_rdata;
    logic             chan_on, half_flag, full_flag, irq;
    logic [CW-1:0]    cnt_left;

    cdma_channel #(.AW(AW), .DW(DW), .CW(CW)) u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .flag_clr(flag_clr), .req(req), .ack(ack),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .chan_on(chan_on), .prio(prio),
        .cnt_left(cnt_left), .half_flag(half_flag), .full_flag(full_flag),
        .irq(irq)
    );

    int total_n = 0;
    int bad_n   = 0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        total_n++;
        if (!ok) begin
            bad_n++;
            $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        return {a ^ 16'h5A5A, ~a};
    endfunction

    function automatic logic [31:0] mkctrl(input bit en, input bit hie, input bit fie,
            input bit m2p, input bit circ, input bit pinc, input bit minc,
            input int psz, input int msz, input int pr);
        logic [31:0] w;
        w = '0;
        w[0] = en; w[1] = hie; w[2] = fie; w[3] = m2p; w[4] = circ;
        w[5] = pinc; w[6] = minc; w[8:7] = psz[1:0]; w[10:9] = msz[1:0];
        w[12:11] = pr[1:0];
        return w;
    endfunction

    // Behavioural reference state
    bit            m_en, m_hie, m_fie, m_dir, m_circ, m_pinc, m_minc;
    logic [1:0]    m_psz, m_msz, m_prio;
    logic [AW-1:0] m_pbase, m_mbase, m_pa, m_ma, rd_addr;
    logic [CW-1:0] m_total, m_cnt;
    bit            m_half, m_full, m_busy;
    bit            pend_wr, pend_cfg, did;
    logic [1:0]    pend_sel, pend_clr;
    logic [31:0]   pend_data;
    logic [7:0]    lfsr = 8'h9D;

    task automatic apply_cfg(input logic [1:0] s, input logic [31:0] d);
        if (s == 2'd0) begin
            if (m_en) begin
                m_en = d[0]; m_hie = d[1]; m_fie = d[2];
            end else begin
                m_en = d[0]; m_hie = d[1]; m_fie = d[2]; m_dir = d[3];
                m_circ = d[4]; m_pinc = d[5]; m_minc = d[6];
                m_psz = d[8:7]; m_msz = d[10:9]; m_prio = d[12:11];
            end
        end else if (!m_en) begin
            if (s == 2'd1) begin m_pbase = d[AW-1:0]; m_pa = d[AW-1:0]; end
            if (s == 2'd2) begin m_mbase = d[AW-1:0]; m_ma = d[AW-1:0]; end
            if (s == 2'd3) begin m_total = d[CW-1:0]; m_cnt = d[CW-1:0]; end
        end
    endtask

    task automatic apply_xfer();
        m_cnt = m_cnt - 1;
        if (m_pinc) m_pa = m_pa + (AW'(1) << m_psz);
        if (m_minc) m_ma = m_ma + (AW'(1) << m_msz);
        if (m_cnt == (m_total >> 1)) m_half = 1;
        if (m_cnt == 0) begin
            m_full = 1;
            if (m_circ) begin
                m_cnt = m_total; m_pa = m_pbase; m_ma = m_mbase;
            end else begin
                m_en = 0;
            end
        end
        m_busy = 0;
    endtask

    always @(negedge clk) begin
        if (rst) begin
            pend_wr = 0; pend_cfg = 0; pend_clr = 0; m_busy = 0;
            bus_ready = 0; bus_rdata = '0;
        end else begin
            did = pend_wr;
            if (pend_cfg) apply_cfg(pend_sel, pend_data);
            m_half = m_half && !pend_clr[0];
            m_full = m_full && !pend_clr[1];
            if (pend_wr) apply_xfer();

            chk(ack == did, "R5", "ack timing", ack, did);
            chk(cnt_left == m_cnt, "R5", "remaining count", cnt_left, m_cnt);
            chk(half_flag == m_half, "R7", "half flag", half_flag, m_half);
            chk(full_flag == m_full, "R8", "full flag", full_flag, m_full);
            chk(irq == ((m_half && m_hie) || (m_full && m_fie)), "R8", "irq",
                irq, (m_half && m_hie) || (m_full && m_fie));
            chk(chan_on == m_en, "R10", "enable state", chan_on, m_en);
            chk(prio == m_prio, "R11", "priority", prio, m_prio);

            if (bus_valid) begin
                if (!m_busy) begin
                    chk(m_en && m_cnt != 0, "R3", "start allowed", 1, m_en && m_cnt != 0);
                    chk(!bus_write, "R3", "read before write", bus_write, 0);
                    m_busy = 1;
                end
                if (!bus_write) begin
                    chk(bus_addr == (m_dir ? m_ma : m_pa), "R6", "read addr",
                        bus_addr, m_dir ? m_ma : m_pa);
                    chk(bus_size == (m_dir ? m_msz : m_psz), "R6", "read size",
                        bus_size, m_dir ? m_msz : m_psz);
                end else begin
                    chk(bus_addr == (m_dir ? m_pa : m_ma), "R6", "write addr",
                        bus_addr, m_dir ? m_pa : m_ma);
                    chk(bus_size == (m_dir ? m_psz : m_msz), "R6", "write size",
                        bus_size, m_dir ? m_psz : m_msz);
                    chk(bus_wdata == pat(rd_addr), "R3", "write data",
                        bus_wdata, pat(rd_addr));
                end
            end else begin
                chk(!m_busy || did, "R4", "valid dropped early", bus_valid, 1);
            end

            // Bus slave for the coming edge, with pseudo-random stalls (R4)
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            bus_ready = lfsr[0] | lfsr[3];
            bus_rdata = pat(bus_addr);
            if (bus_valid && !bus_write && bus_ready) rd_addr = bus_addr;
            pend_wr   = bus_valid && bus_write && bus_ready;
            pend_cfg  = cfg_we;
            pend_sel  = cfg_sel;
            pend_data = cfg_wdata;
            pend_clr  = flag_clr;
        end
    end

    task automatic cfg_write(input logic [1:0] s, input logic [31:0] d);
        cfg_we = 1; cfg_sel = s; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 0;
        @(posedge clk); #1;
    endtask

    task automatic clear_flags();
        flag_clr = 2'b11;
        @(posedge clk); #1;
        flag_clr = 2'b00;
        @(posedge clk); #1;
    endtask

    task automatic run_req(input int n);
        for (int i = 0; i < n; i++) begin
            int w;
            req = 1; w = 0;
            while (!ack && w < 100) begin
                @(posedge clk); #1;
                w++;
            end
            req = 0;
            @(posedge clk); #1;
        end
    endtask

    task automatic idle_req(input int cycles);
        req = 1;
        repeat (cycles) begin
            @(posedge clk); #1;
            chk(!bus_valid, "R10", "request ignored", bus_valid, 0);
        end
        req = 0;
        @(posedge clk); #1;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total_n, bad_n);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total_n++; bad_n++;
        $display("FAIL R3 watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        rst = 1; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0; flag_clr = 0; req = 0;
        {m_en, m_hie, m_fie, m_dir, m_circ, m_pinc, m_minc} = '0;
        m_psz = 0; m_msz = 0; m_prio = 0; m_pbase = 0; m_mbase = 0;
        m_pa = 0; m_ma = 0; m_total = 0; m_cnt = 0; m_half = 0; m_full = 0;
        rd_addr = 0;
        repeat (4) @(posedge clk);
        #1 rst = 0;
        // R1 reset state
        chk(!chan_on, "R1", "enable after reset", chan_on, 0);
        chk(cnt_left == 0, "R1", "count after reset", cnt_left, 0);
        chk(!bus_valid && !ack && !irq, "R1", "outputs after reset",
            {bus_valid, ack, irq}, 0);
        chk(prio == 0 && !half_flag && !full_flag, "R1", "flags after reset",
            {prio, half_flag, full_flag}, 0);

        // Circular peripheral-to-memory stream, word source, halfword memory step
        cfg_write(2'd1, 32'h0100);
        cfg_write(2'd2, 32'h2000);
        cfg_write(2'd3, 32'd8);
        chk(cnt_left == 8, "R2", "count loaded while disabled", cnt_left, 8);
        cfg_write(2'd0, mkctrl(1, 1, 1, 0, 1, 0, 1, 2, 1, 2));
        run_req(3);
        chk(!half_flag, "R7", "no half before midpoint", half_flag, 0);
        run_req(1);
        chk(half_flag && irq, "R7", "half at midpoint", {half_flag, irq}, 2'b11);
        run_req(4);
        chk(full_flag && chan_on && cnt_left == 8, "R9", "circular reload",
            {full_flag, chan_on, cnt_left}, {1'b1, 1'b1, 6'd8});
        clear_flags();
        chk(!irq, "R8", "flags cleared", irq, 0);
        run_req(3);

        // Writes while enabled are ignored
        cfg_write(2'd3, 32'd5);
        chk(cnt_left == 5, "R2", "count write ignored", cnt_left, 5);
        cfg_write(2'd1, 32'h0400);
        cfg_write(2'd0, mkctrl(1, 0, 1, 1, 0, 1, 0, 0, 0, 1));
        chk(prio == 2, "R12", "priority locked while enabled", prio, 2);
        run_req(2);
        chk(chan_on, "R12", "circular mode locked", chan_on, 1);

        // One-shot memory-to-peripheral, odd total
        cfg_write(2'd0, 32'h0);
        clear_flags();
        cfg_write(2'd1, 32'h0300);
        cfg_write(2'd2, 32'h4000);
        cfg_write(2'd3, 32'd3);
        cfg_write(2'd0, mkctrl(1, 1, 1, 1, 0, 1, 1, 0, 2, 3));
        chk(prio == 3, "R11", "priority output", prio, 3);
        run_req(2);
        chk(half_flag && !full_flag, "R7", "half of odd total", {half_flag, full_flag}, 2'b10);
        run_req(1);
        chk(!chan_on && full_flag, "R10", "one-shot stop", {chan_on, full_flag}, 2'b01);
        idle_req(12);

        // Total of one: both flags at once, circular
        clear_flags();
        cfg_write(2'd3, 32'd1);
        cfg_write(2'd0, mkctrl(1, 1, 0, 0, 1, 1, 1, 1, 1, 0));
        run_req(2);
        chk(half_flag && full_flag && cnt_left == 1, "R7", "total one flags",
            {half_flag, full_flag, cnt_left}, {1'b1, 1'b1, 6'd1});

        // Enabled with zero count: requests not served
        cfg_write(2'd0, 32'h0);
        cfg_write(2'd3, 32'd0);
        cfg_write(2'd0, mkctrl(1, 0, 0, 0, 1, 0, 0, 0, 0, 0));
        idle_req(8);
        chk(chan_on, "R3", "zero count stays enabled", chan_on, 1);

        repeat (4) @(posedge clk);
        finish_run();
    end

endmodule